// File: doc/BRIEF.md
# Decimating Pixel Demultiplexer

This block is the digital front end of a six-channel display column driver. A display controller sends a fast stream of 10-bit gamma-corrected pixel codes. The block stores them one at a time in six input latches. It then releases all six together, on a single transfer strobe, into output holding registers. Those registers feed slower per-channel converters. This turns a serial pixel stream into parallel columns, six at a time.

Several settings can change while the block runs:
- **Scan direction:** channel 0 upward for one projection orientation, or channel 5 downward for the mirrored one.
- **Alternate-slot capture:** the block keeps only every other sample, so two devices can share one double-rate data path.
- **Output polarity inversion.**
- **Loading mode:** an internal pointer (sequential) or an explicit channel address (addressed).

The controller asserts a start-of-line input before each new line of pixels.

Top module: `pixel_decimator`

## Requirements
- R1: A synchronous active-high `rst` clears all six latches, all output lanes, `inv_out`, the fill pointer, the fill count and the phase bit.
- R2: The output lanes and `inv_out` change only on the clock edge where `xfer` is high. All six lanes update on that edge from the latch contents. Between transfers the outputs hold steady, whatever is captured.
- R3: With `rev`=0, sequential captures fill channel 0 first and move up to channel 5. Channel k appears on `dout[k*10 +: 10]`.
- R4: With `rev`=1, sequential captures fill channel 5 first and move down to channel 0.
- R5: Alternate-slot capture:
  - The phase bit toggles on every cycle that has `din_valid` high and `sol` low.
  - `sol` clears the phase bit to 0.
  - With `alt_en`=1, a sample is accepted only when the phase bit equals `alt_sel`.
  - With `alt_en`=0, every valid sample is accepted.
- R6: On a transfer with `invert`=1, each lane receives 1023 minus its latched code. `inv_out` takes the value `invert` had on the transfer edge.
- R7: With `addr_mode`=1, an accepted sample goes to the latch chosen by `wr_addr`. Addresses 6 and 7 change no latch.
- R8: In sequential mode, the fill pointer returns to the first channel of the current direction on `xfer` or `sol`. After six captures, later samples are dropped until the pointer is reset.
- R9: When `xfer` and an accepted sequential capture fall in the same cycle:
  - The transfer carries the latch contents from before that capture.
  - The new word goes to the first channel of the next line.
  - The following capture goes to the second channel.
- R10: A `din_valid` sample in a cycle with `sol` high is discarded. `sol` leaves the latch contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rev | input | 1 | Scan direction: 0 fills channel 0 upward, 1 fills channel 5 downward |
| alt_en | input | 1 | Enables alternate-slot capture |
| alt_sel | input | 1 | Phase value on which samples are kept |
| invert | input | 1 | Output polarity select, sampled on transfer |
| addr_mode | input | 1 | 0 = sequential pointer, 1 = addressed loading |
| wr_addr | input | 3 | Target latch in addressed mode |
| sol | input | 1 | Start of line: resets pointer and phase |
| din_valid | input | 1 | Sample slot marker for `din` |
| din | input | 10 | Pixel code |
| xfer | input | 1 | Transfer strobe: copies all latches to the outputs |
| dout | output | 60 | Six output lanes, lane k at bits k*10+9..k*10 |
| inv_out | output | 1 | Registered polarity flag for downstream level shifting |

## Verification
The assertions check several properties on every cycle:
- The outputs stay still on all cycles without a transfer.
- The polarity flag follows `invert` as it stood at the transfer.
- The fill count never exceeds six.
- The fill count returns to zero after `sol` and to at most one after a transfer.

Only the bench's scenarios can show that the right code reaches the right lane. They cover:
- both scan directions;
- dropped seventh and eighth samples;
- addressed writes and ignored addresses;
- alternate-slot selection on both phases;
- the inverted arithmetic;
- the handling of a transfer that coincides with a capture.

A scoreboard model predicts all six lanes for each of these.

// File: rtl/pixdec_pkg.sv
package pixdec_pkg;

    // Datapath geometry
    localparam int CODE_W = 10;
    localparam int NCH    = 6;
    localparam int IDX_W  = $clog2(NCH);
    localparam int CNT_W  = $clog2(NCH + 1);
    localparam int DOUT_W = NCH * CODE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    localparam idx_t  LAST_IDX = idx_t'(NCH - 1);
    localparam cnt_t  FULL_CNT = cnt_t'(NCH);
    localparam code_t CODE_MAX = code_t'((1 << CODE_W) - 1);

    // Latch that a sequential line starts from, given the scan direction
    function automatic idx_t first_slot(input logic rev);
        return rev ? LAST_IDX : idx_t'(0);
    endfunction

    // Next latch along the scan direction
    function automatic idx_t step_slot(input idx_t cur, input logic rev);
        if (rev)
            return (cur == idx_t'(0)) ? LAST_IDX : cur - idx_t'(1);
        else
            return (cur == LAST_IDX) ? idx_t'(0) : cur + idx_t'(1);
    endfunction

    // Mirrored code for inverted polarity
    function automatic code_t mirror_code(input code_t c);
        return CODE_MAX - c;
    endfunction

endpackage

// File: rtl/pixdec_sequencer.sv
module pixdec_sequencer
    import pixdec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rev,
    input  logic alt_en,
    input  logic alt_sel,
    input  logic addr_mode,
    input  idx_t wr_addr,
    input  logic sol,
    input  logic din_valid,
    input  logic xfer,
    output logic wr_en,
    output idx_t wr_idx,
    output cnt_t fill_cnt
);

    idx_t ptr_q, ptr_d, start, seq_slot;
    cnt_t cnt_q, cnt_d;
    logic phase_q, phase_d;
    logic accept, seq_ok, seq_wr;

    always_comb begin
        start  = first_slot(rev);
        accept = din_valid && !sol && (!alt_en || (phase_q == alt_sel));

        // A transfer in the same cycle opens a new line: the word lands in the first slot
        seq_slot = xfer ? start : ptr_q;
        seq_ok   = xfer || (cnt_q < FULL_CNT);

        wr_en  = accept && (addr_mode ? (wr_addr <= LAST_IDX) : seq_ok);
        wr_idx = addr_mode ? wr_addr : seq_slot;
        seq_wr = wr_en && !addr_mode;

        phase_d = sol ? 1'b0 : (din_valid ? ~phase_q : phase_q);

        ptr_d = ptr_q;
        cnt_d = cnt_q;
        if (sol) begin
            ptr_d = start;
            cnt_d = '0;
        end else if (xfer) begin
            if (seq_wr) begin
                ptr_d = step_slot(start, rev);
                cnt_d = cnt_t'(1);
            end else begin
                ptr_d = start;
                cnt_d = '0;
            end
        end else if (seq_wr) begin
            ptr_d = step_slot(ptr_q, rev);
            cnt_d = cnt_q + cnt_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else begin
            ptr_q   <= ptr_d;
            cnt_q   <= cnt_d;
            phase_q <= phase_d;
        end
    end

    assign fill_cnt = cnt_q;

endmodule

// File: rtl/pixdec_latch_bank.sv
module pixdec_latch_bank
    import pixdec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  code_t din,
    output code_t lat [NCH]
);

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                lat[g] <= '0;
            else if (wr_en && (wr_idx == idx_t'(g)))
                lat[g] <= din;
        end
    end

endmodule

// File: rtl/pixdec_transfer.sv
module pixdec_transfer
    import pixdec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  xfer,
    input  logic  invert,
    input  code_t lat  [NCH],
    output code_t lane [NCH],
    output logic  inv_out
);

    for (genvar g = 0; g < NCH; g++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst)
                lane[g] <= '0;
            else if (xfer)
                lane[g] <= invert ? mirror_code(lat[g]) : lat[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            inv_out <= 1'b0;
        else if (xfer)
            inv_out <= invert;
    end

endmodule

// File: rtl/pixel_decimator.sv
module pixel_decimator
    import pixdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rev,
    input  logic              alt_en,
    input  logic              alt_sel,
    input  logic              invert,
    input  logic              addr_mode,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic              sol,
    input  logic              din_valid,
    input  logic [CODE_W-1:0] din,
    input  logic              xfer,
    output logic [DOUT_W-1:0] dout,
    output logic              inv_out
);

    logic  wr_en;
    idx_t  wr_idx;
    cnt_t  fill_cnt;
    code_t lat  [NCH];
    code_t lane [NCH];

    pixdec_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .rev       (rev),
        .alt_en    (alt_en),
        .alt_sel   (alt_sel),
        .addr_mode (addr_mode),
        .wr_addr   (wr_addr),
        .sol       (sol),
        .din_valid (din_valid),
        .xfer      (xfer),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .fill_cnt  (fill_cnt)
    );

    pixdec_latch_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .din    (din),
        .lat    (lat)
    );

    pixdec_transfer u_xfr (
        .clk     (clk),
        .rst     (rst),
        .xfer    (xfer),
        .invert  (invert),
        .lat     (lat),
        .lane    (lane),
        .inv_out (inv_out)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_pack
        assign dout[g*CODE_W +: CODE_W] = lane[g];
    end

endmodule

// File: rtl/pixdec_checks.sv
module pixdec_checks
    import pixdec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              xfer,
    input logic              sol,
    input logic              invert,
    input logic [DOUT_W-1:0] dout,
    input logic              inv_out,
    input cnt_t              fill_cnt
);

    // R1: reset leaves outputs and fill state empty
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (dout == '0 && !inv_out && fill_cnt == '0));

    // R2: no transfer, no output movement
    a_r2_outputs_hold: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> ($stable(dout) && $stable(inv_out)));

    // R6: polarity flag captured at transfer
    a_r6_flag_follows: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (inv_out == $past(invert)));

    // R8: fill count never passes the channel count
    a_r8_count_bounded: assert property (@(posedge clk) disable iff (rst)
        fill_cnt <= FULL_CNT);

    // R8: start of line restarts the fill
    a_r8_sol_restart: assert property (@(posedge clk) disable iff (rst)
        sol |=> (fill_cnt == '0));

    // R9: a transfer leaves at most the one coinciding word queued
    a_r9_xfer_restart: assert property (@(posedge clk) disable iff (rst)
        (xfer && !sol) |=> (fill_cnt <= cnt_t'(1)));

endmodule

bind pixel_decimator pixdec_checks u_checks (
    .clk      (clk),
    .rst      (rst),
    .xfer     (xfer),
    .sol      (sol),
    .invert   (invert),
    .dout     (dout),
    .inv_out  (inv_out),
    .fill_cnt (fill_cnt)
);

// File: tb/pixel_decimator_test.sv
`timescale 1ns/1ps
module pixel_decimator_test;
    import pixdec_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rev = 1'b0, alt_en = 1'b0, alt_sel = 1'b0, invert = 1'b0, addr_mode = 1'b0;
    logic sol = 1'b0, din_valid = 1'b0, xfer = 1'b0;
    logic [IDX_W-1:0]  wr_addr = '0;
    logic [CODE_W-1:0] din = '0;
    logic [DOUT_W-1:0] dout;
    logic              inv_out;

    always #4 clk = ~clk;   // 125 MHz

    pixel_decimator uut (
        .clk(clk), .rst(rst), .rev(rev), .alt_en(alt_en), .alt_sel(alt_sel),
        .invert(invert), .addr_mode(addr_mode), .wr_addr(wr_addr), .sol(sol),
        .din_valid(din_valid), .din(din), .xfer(xfer), .dout(dout), .inv_out(inv_out)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model
    int m_lat [NCH];
    int m_ptr = 0;
    int m_cnt = 0;
    bit m_phase = 1'b0;
    string cur_tag = "R1";
    logic [DOUT_W-1:0] last_exp = '0;

    logic [DOUT_W-1:0] exp_q [$];
    logic              inv_q [$];
    string             tag_q [$];

    function automatic int first_m();
        return rev ? NCH - 1 : 0;
    endfunction

    function automatic int step_m(input int i);
        if (rev) return (i == 0) ? NCH - 1 : i - 1;
        return (i == NCH - 1) ? 0 : i + 1;
    endfunction

    task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock cycle of stimulus, with the model stepped alongside
    task automatic cyc(input bit v, input int d, input int a, input bit x, input bit s);
        bit acc;
        logic [DOUT_W-1:0] ev;
        din_valid = v;
        din       = code_t'(d);
        wr_addr   = idx_t'(a);
        xfer      = x;
        sol       = s;
        if (x) begin
            for (int g = 0; g < NCH; g++)
                ev[g*CODE_W +: CODE_W] = invert ? code_t'(1023 - m_lat[g]) : code_t'(m_lat[g]);
            exp_q.push_back(ev);
            inv_q.push_back(invert);
            tag_q.push_back(cur_tag);
            last_exp = ev;
        end
        if (s) begin
            m_phase = 1'b0;
            m_ptr   = first_m();
            m_cnt   = 0;
        end else begin
            acc = v && (!alt_en || (m_phase == alt_sel));
            if (v) m_phase = ~m_phase;
            if (acc && addr_mode) begin
                if (a < NCH) m_lat[a] = d;
            end else if (acc && x) begin
                m_lat[first_m()] = d;
                m_ptr = step_m(first_m());
                m_cnt = 1;
            end else if (acc && m_cnt < NCH) begin
                m_lat[m_ptr] = d;
                m_ptr = step_m(m_ptr);
                m_cnt++;
            end
            if (x && !(acc && !addr_mode)) begin
                m_ptr = first_m();
                m_cnt = 0;
            end
        end
        @(negedge clk);
        din_valid = 1'b0;
        xfer      = 1'b0;
        sol       = 1'b0;
    endtask

    task automatic send_run(input int base, input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, base + i, 0, 1'b0, 1'b0);
    endtask

    task automatic do_xfer();
        cyc(1'b0, 0, 0, 1'b1, 1'b0);
    endtask

    task automatic start_line();
        cyc(1'b0, 0, 0, 1'b0, 1'b1);
    endtask

    // Monitor: pop expected lanes one edge after each transfer
    initial begin
        forever begin
            @(posedge clk);
            if (xfer === 1'b1) begin
                logic [DOUT_W-1:0] e;
                logic ei;
                string t;
                @(negedge clk);
                e  = exp_q.pop_front();
                ei = inv_q.pop_front();
                t  = tag_q.pop_front();
                for (int g = 0; g < NCH; g++)
                    check($sformatf("%s lane%0d", t, g), dout[g*CODE_W +: CODE_W], e[g*CODE_W +: CODE_W]);
                check($sformatf("%s inv_out", t), inv_out, ei);
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int g = 0; g < NCH; g++) m_lat[g] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: cleared outputs after reset
        check("R1 dout", dout, 0);
        check("R1 inv_out", inv_out, 0);
        do_xfer();                        // R1: latches empty too
        repeat (2) @(negedge clk);

        // R3: forward fill, true polarity
        cur_tag = "R3";
        start_line();
        send_run(100, 6);
        do_xfer();
        // R2: captures without a strobe leave outputs alone
        send_run(300, 3);
        check("R2 hold", dout, last_exp);

        // R4 + R6: reverse fill, inverted
        cur_tag = "R4_R6";
        rev = 1'b1; invert = 1'b1;
        start_line();
        send_run(200, 6);
        do_xfer();
        invert = 1'b0;
        cur_tag = "R4";
        start_line();
        send_run(10, 6);
        do_xfer();

        // R8: seventh and eighth samples dropped
        cur_tag = "R8";
        rev = 1'b0;
        start_line();
        send_run(400, 8);
        do_xfer();

        // R10: sample during start-of-line discarded, latches kept
        cur_tag = "R10";
        send_run(500, 3);
        cyc(1'b1, 999, 0, 1'b0, 1'b1);
        send_run(600, 2);
        do_xfer();

        // R9: transfer coincides with a capture
        cur_tag = "R9";
        start_line();
        send_run(700, 6);
        cyc(1'b1, 750, 0, 1'b1, 1'b0);
        send_run(760, 5);
        do_xfer();
        rev = 1'b1;
        start_line();
        send_run(20, 6);
        cyc(1'b1, 55, 0, 1'b1, 1'b0);
        send_run(60, 1);
        do_xfer();

        // R7: addressed loading, out-of-range addresses ignored
        cur_tag = "R7";
        rev = 1'b0; addr_mode = 1'b1;
        start_line();
        cyc(1'b1, 811, 3, 1'b0, 1'b0);
        cyc(1'b1, 822, 0, 1'b0, 1'b0);
        cyc(1'b1, 833, 5, 1'b0, 1'b0);
        cyc(1'b1, 844, 6, 1'b0, 1'b0);
        cyc(1'b1, 855, 7, 1'b0, 1'b0);
        do_xfer();
        invert = 1'b1;
        cur_tag = "R7_R6";
        cyc(1'b1, 866, 1, 1'b0, 1'b0);
        cyc(1'b1, 1023, 2, 1'b0, 1'b0);
        cyc(1'b1, 0, 4, 1'b0, 1'b0);
        do_xfer();
        invert = 1'b0; addr_mode = 1'b0;

        // R5: alternate-slot capture on each phase
        cur_tag = "R5_odd";
        alt_en = 1'b1; alt_sel = 1'b1;
        start_line();
        send_run(900, 12);
        do_xfer();
        cur_tag = "R5_even";
        alt_sel = 1'b0; rev = 1'b1;
        start_line();
        send_run(30, 12);
        do_xfer();
        alt_en = 1'b0; rev = 1'b0;

        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule